// File: doc/BRIEF.md
# Framed Slotted ALOHA Tag Inventory Controller

This block is the digital control core of a passive identification tag that takes part in a framed slotted ALOHA inventory round. It receives commands that have already been decoded. Each command carries a 3-bit command code, a frame-size exponent Q and an echoed 16-bit handle. The block keeps a 16-bit slot counter and loads it from an on-chip pseudo-random source, masked to the range 0 to 2^Q − 1. Each decrement command lowers the counter by one. When the counter reaches its slot, the block asks the transmitter to send the tag's handle. A matching acknowledge then releases the stored data word, and a second matching acknowledge retires the tag.

After a collision the reader issues a redraw command, and every tag that has not retired picks a new slot under the Q it already holds. A retired tag stays silent until a session clear command or a hardware reset. Reply requests leave the block as a one-cycle strobe with a 16-bit word and a flag that tells a handle from a payload. The current phase and the slot counter are also visible as outputs.

Command codes: 0 none, 1 load, 2 decrement, 3 acknowledge, 4 redraw, 5 clear; codes 6 and 7 are ignored. Phase codes on `tag_phase`: 0 idle, 1 counting, 2 handle sent, 3 data sent, 4 retired.

Top module: `slot_tag_ctrl`

## Requirements
- R1: After reset, `tag_phase` is 0, `slot_count` is 0 and no reply is issued. In phase 0, decrement, acknowledge and redraw commands change nothing.
- R2: A load command sets `slot_count` to the random word ANDed with 2^Q − 1, where Q is taken from `cmd_q` and any Q of 16 or more keeps all 16 bits. It also stores Q, so every bit above Q is zero while the tag is in phases 1 to 3.
- R3: The random word comes from a 16-bit maximal-length shift register with feedback polynomial x^16+x^14+x^13+x^11+1 and a non-zero seed. It shifts left by one every clock after reset. A command uses the value the register holds in the cycle the command is presented.
- R4: In phase 1, a decrement lowers `slot_count` by exactly one. A decrement while the count is already 0 leaves it at 0.
- R5: When a decrement takes the count from 1 to 0, or a load or redraw draws 0, the tag moves to phase 2. One cycle after the command, it issues a reply with `reply_is_data`=0 and `reply_word` equal to `tag_handle`.
- R6: In phase 2, an acknowledge whose `cmd_handle` equals `tag_handle` issues a reply with `reply_is_data`=1 and `reply_word` equal to `data_word`, and moves the tag to phase 3.
- R7: In phase 2 or 3, an acknowledge with a non-matching handle returns the tag to phase 1 with `slot_count` unchanged and no reply.
- R8: In phase 2 or 3, decrement commands are ignored.
- R9: In phase 3, a matching acknowledge moves the tag to phase 4 without a reply. In phase 4, load, decrement, acknowledge and redraw are ignored.
- R10: In phases 1 to 3, a redraw reloads the counter with the random word masked by the stored Q, and `cmd_q` is ignored. In phase 0 a redraw does nothing.
- R11: A clear command in any phase returns the tag to phase 0 with `slot_count` 0.
- R12: `reply_valid` is high only in the cycle after the command that caused the reply. While it is low, `reply_is_data` is 0 and `reply_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 3 | Decoded command code, 0 when there is no command |
| cmd_q | input | 5 | Frame-size exponent Q for a load |
| cmd_handle | input | 16 | Handle echoed by the reader in an acknowledge |
| tag_handle | input | 16 | This tag's handle |
| data_word | input | 16 | Stored payload word |
| reply_valid | output | 1 | One-cycle reply request |
| reply_is_data | output | 1 | 1 = payload reply, 0 = handle reply |
| reply_word | output | 16 | Reply contents |
| slot_count | output | 16 | Current slot counter |
| tag_phase | output | 3 | Inventory phase code |

## Verification
Every result of a command is registered, so the new phase, the new slot count and any reply strobe all appear after the single rising edge that samples the command. They must be gone, or updated, one edge later. The bench drives each command on a falling edge and holds it for exactly one cycle. A behavioural reference model advances on the same rising edge, and every output is compared against it at each falling edge, half a cycle after the edge that made the change. The directed checks also sample at that falling edge, so a reply strobe is seen exactly once.

// File: rtl/slot_tag_pkg.sv
package slot_tag_pkg;

  localparam int SLOT_W = 16;
  localparam int Q_W    = 5;
  localparam int PH_W   = 3;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_STEP   = 3'd2,
    OP_ACK    = 3'd3,
    OP_REDRAW = 3'd4,
    OP_CLEAR  = 3'd5
  } op_e;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE    = 3'd0,
    PH_COUNT   = 3'd1,
    PH_HANDLE  = 3'd2,
    PH_DATA    = 3'd3,
    PH_RETIRED = 3'd4
  } phase_e;

  // Low Q bits set; Q of SLOT_W or more keeps the whole word.
  function automatic logic [SLOT_W-1:0] range_mask(input logic [Q_W-1:0] q);
    logic [SLOT_W-1:0] m;
    if (int'(q) >= SLOT_W) m = '1;
    else                   m = (SLOT_W'(1) << q) - SLOT_W'(1);
    return m;
  endfunction

  function automatic logic [SLOT_W-1:0] draw_slot(input logic [SLOT_W-1:0] rnd,
                                                 input logic [Q_W-1:0]    q);
    return rnd & range_mask(q);
  endfunction

endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= lfsr_next(state);
  end

endmodule

// File: rtl/tag_slot_counter.sv
module tag_slot_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count
);

  logic can_step;
  assign can_step = step && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clear)    count <= '0;
    else if (load)     count <= load_val;
    else if (can_step) count <= count - W'(1);
  end

endmodule

// File: rtl/tag_phase_fsm.sv
module tag_phase_fsm
  import slot_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_code,
  input  logic [Q_W-1:0]    cmd_q,
  input  logic [SLOT_W-1:0] cmd_handle,
  input  logic [SLOT_W-1:0] tag_handle,
  input  logic [SLOT_W-1:0] data_word,
  input  logic [SLOT_W-1:0] rnd,
  input  logic [SLOT_W-1:0] count,
  output phase_e            phase,
  output logic [Q_W-1:0]    q_cur,
  output logic              ctr_clear,
  output logic              ctr_load,
  output logic [SLOT_W-1:0] ctr_load_val,
  output logic              ctr_step,
  output logic              ev_slot_hit,
  output logic              ev_handle_match,
  output logic              reply_valid,
  output logic              reply_is_data,
  output logic [SLOT_W-1:0] reply_word
);

  op_e               op;
  phase_e            nxt_phase;
  logic [Q_W-1:0]    nxt_q;
  logic [SLOT_W-1:0] draw_new, draw_cur;
  logic              draw_en;
  logic              rv_n, rd_n;
  logic [SLOT_W-1:0] rw_n;
  logic              active;

  assign op              = op_e'(cmd_code);
  assign draw_new        = draw_slot(rnd, cmd_q);
  assign draw_cur        = draw_slot(rnd, q_cur);
  assign ev_handle_match = (cmd_handle == tag_handle);
  assign active          = (phase == PH_COUNT) || (phase == PH_HANDLE) || (phase == PH_DATA);

  always_comb begin
    nxt_phase    = phase;
    nxt_q        = q_cur;
    ctr_clear    = 1'b0;
    ctr_load     = 1'b0;
    ctr_load_val = '0;
    ctr_step     = 1'b0;
    draw_en      = 1'b0;
    ev_slot_hit  = 1'b0;
    rv_n         = 1'b0;
    rd_n         = 1'b0;
    rw_n         = '0;
    case (op)
      OP_CLEAR: begin
        nxt_phase = PH_IDLE;
        nxt_q     = '0;
        ctr_clear = 1'b1;
      end
      OP_LOAD: begin
        if (phase != PH_RETIRED) begin
          nxt_q        = cmd_q;
          ctr_load     = 1'b1;
          ctr_load_val = draw_new;
          draw_en      = 1'b1;
        end
      end
      OP_REDRAW: begin
        if (active) begin
          ctr_load     = 1'b1;
          ctr_load_val = draw_cur;
          draw_en      = 1'b1;
        end
      end
      OP_STEP: begin
        if (phase == PH_COUNT && count != '0) begin
          ctr_step = 1'b1;
          if (count == SLOT_W'(1)) ev_slot_hit = 1'b1;
        end
      end
      OP_ACK: begin
        if (phase == PH_HANDLE) begin
          if (ev_handle_match) begin
            nxt_phase = PH_DATA;
            rv_n      = 1'b1;
            rd_n      = 1'b1;
            rw_n      = data_word;
          end else begin
            nxt_phase = PH_COUNT;
          end
        end else if (phase == PH_DATA) begin
          nxt_phase = ev_handle_match ? PH_RETIRED : PH_COUNT;
        end
      end
      default: ;
    endcase
    if (draw_en) begin
      if (ctr_load_val == '0) ev_slot_hit = 1'b1;
      else                    nxt_phase   = PH_COUNT;
    end
    if (ev_slot_hit) begin
      nxt_phase = PH_HANDLE;
      rv_n      = 1'b1;
      rd_n      = 1'b0;
      rw_n      = tag_handle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      q_cur         <= '0;
      reply_valid   <= 1'b0;
      reply_is_data <= 1'b0;
      reply_word    <= '0;
    end else begin
      phase         <= nxt_phase;
      q_cur         <= nxt_q;
      reply_valid   <= rv_n;
      reply_is_data <= rd_n;
      reply_word    <= rw_n;
    end
  end

endmodule

// File: rtl/slot_tag_ctrl.sv
module slot_tag_ctrl
  import slot_tag_pkg::*;
#(
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cmd_code,
  input  logic [4:0]  cmd_q,
  input  logic [15:0] cmd_handle,
  input  logic [15:0] tag_handle,
  input  logic [15:0] data_word,
  output logic        reply_valid,
  output logic        reply_is_data,
  output logic [15:0] reply_word,
  output logic [15:0] slot_count,
  output logic [2:0]  tag_phase
);

  logic [SLOT_W-1:0] lfsr_state;
  logic [SLOT_W-1:0] ctr_load_val;
  logic              ctr_clear, ctr_load, ctr_step;
  logic [Q_W-1:0]    q_cur;
  logic              ev_slot_hit, ev_handle_match;
  phase_e            phase;

  tag_lfsr #(.W(SLOT_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_state)
  );

  tag_slot_counter #(.W(SLOT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ctr_clear),
    .load     (ctr_load),
    .load_val (ctr_load_val),
    .step     (ctr_step),
    .count    (slot_count)
  );

  tag_phase_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_code        (cmd_code),
    .cmd_q           (cmd_q),
    .cmd_handle      (cmd_handle),
    .tag_handle      (tag_handle),
    .data_word       (data_word),
    .rnd             (lfsr_state),
    .count           (slot_count),
    .phase           (phase),
    .q_cur           (q_cur),
    .ctr_clear       (ctr_clear),
    .ctr_load        (ctr_load),
    .ctr_load_val    (ctr_load_val),
    .ctr_step        (ctr_step),
    .ev_slot_hit     (ev_slot_hit),
    .ev_handle_match (ev_handle_match),
    .reply_valid     (reply_valid),
    .reply_is_data   (reply_is_data),
    .reply_word      (reply_word)
  );

  assign tag_phase = phase;

endmodule

// File: rtl/slot_tag_ctrl_checker.sv
module slot_tag_ctrl_checker
  import slot_tag_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cmd_code,
  input logic [15:0] tag_handle,
  input logic        reply_valid,
  input logic        reply_is_data,
  input logic [15:0] reply_word,
  input logic [15:0] slot_count,
  input logic [2:0]  tag_phase,
  input logic [4:0]  q_cur,
  input logic [15:0] lfsr_state,
  input logic        ev_handle_match,
  input logic        ev_slot_hit
);

  always @(posedge clk) begin
    if (rst_n) begin
      assert_lfsr_nonzero_R3: assert (lfsr_state != 16'h0)
        else $error("R3 random register reached zero");
    end
  end

  assert_range_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_phase == 3'd1) |-> ((slot_count & ~range_mask(q_cur)) == 16'h0));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_phase == 3'd1 && cmd_code == 3'd2 && slot_count > 16'd1)
      |=> (slot_count == $past(slot_count) - 16'd1));

  assert_handle_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && !reply_is_data) |-> (reply_word == tag_handle && tag_phase == 3'd2));

  assert_hit_goes_handle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slot_hit |=> (reply_valid && tag_phase == 3'd2));

  assert_data_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_is_data) |-> (tag_phase == 3'd3));

  assert_bad_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_phase == 3'd2 && cmd_code == 3'd3 && !ev_handle_match)
      |=> (tag_phase == 3'd1 && slot_count == $past(slot_count) && !reply_valid));

  assert_wait_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tag_phase == 3'd2 || tag_phase == 3'd3) && cmd_code == 3'd2)
      |=> $stable(slot_count));

  assert_retired_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_phase == 3'd4 && cmd_code != 3'd5) |=> (tag_phase == 3'd4 && !reply_valid));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd5) |=> (tag_phase == 3'd0 && slot_count == 16'h0));

  assert_quiet_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reply_valid |-> (!reply_is_data && reply_word == 16'h0));

endmodule

bind slot_tag_ctrl slot_tag_ctrl_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_code        (cmd_code),
  .tag_handle      (tag_handle),
  .reply_valid     (reply_valid),
  .reply_is_data   (reply_is_data),
  .reply_word      (reply_word),
  .slot_count      (slot_count),
  .tag_phase       (tag_phase),
  .q_cur           (q_cur),
  .lfsr_state      (lfsr_state),
  .ev_handle_match (ev_handle_match),
  .ev_slot_hit     (ev_slot_hit)
);

// File: tb/slot_tag_ctrl_tb_top.sv
module slot_tag_ctrl_tb_top;

  localparam logic [15:0] SEED  = 16'hACE1;
  localparam logic [15:0] MYH   = 16'h5A3C;
  localparam logic [15:0] MYD   = 16'hC0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [4:0]  cmd_q = 5'd0;
  logic [15:0] cmd_handle = 16'h0;
  logic        reply_valid, reply_is_data;
  logic [15:0] reply_word, slot_count;
  logic [2:0]  tag_phase;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  always #10 clk = ~clk;

  slot_tag_ctrl #(.LFSR_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_q(cmd_q),
    .cmd_handle(cmd_handle), .tag_handle(MYH), .data_word(MYD),
    .reply_valid(reply_valid), .reply_is_data(reply_is_data),
    .reply_word(reply_word), .slot_count(slot_count), .tag_phase(tag_phase)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_lfsr, m_cnt, m_rw, t_rnd;
  int          m_phase, m_q;
  bit          m_rv, m_rd, t_draw;

  function automatic logic [15:0] m_adv(input logic [15:0] v);
    logic fb;
    fb = v[15] ^ v[13] ^ v[12] ^ v[10];
    return {v[14:0], fb};
  endfunction

  function automatic logic [15:0] lim(input int q);
    if (q >= 16) return 16'hFFFF;
    return 16'((32'd1 << q) - 1);
  endfunction

  task automatic m_handle_reply();
    m_phase = 2; m_rv = 1; m_rd = 0; m_rw = MYH;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = SEED; m_cnt = 0; m_phase = 0; m_q = 0;
      m_rv = 0; m_rd = 0; m_rw = 0;
    end else begin
      m_rv = 0; m_rd = 0; m_rw = 0;
      t_rnd = m_lfsr; t_draw = 0;
      if (cmd_code == 3'd5) begin
        m_phase = 0; m_cnt = 0; m_q = 0;
      end else if (m_phase != 4) begin
        case (cmd_code)
          3'd1: begin m_q = cmd_q; m_cnt = t_rnd & lim(m_q); t_draw = 1; end
          3'd4: if (m_phase != 0) begin m_cnt = t_rnd & lim(m_q); t_draw = 1; end
          3'd2: if (m_phase == 1 && m_cnt != 0) begin
                  m_cnt = m_cnt - 1;
                  if (m_cnt == 0) m_handle_reply();
                end
          3'd3: if (m_phase == 2) begin
                  if (cmd_handle == MYH) begin
                    m_phase = 3; m_rv = 1; m_rd = 1; m_rw = MYD;
                  end else m_phase = 1;
                end else if (m_phase == 3) begin
                  m_phase = (cmd_handle == MYH) ? 4 : 1;
                end
          default: ;
        endcase
        if (t_draw) begin
          if (m_cnt == 0) m_handle_reply();
          else m_phase = 1;
        end
      end
      m_lfsr = m_adv(m_lfsr);
    end
  end

  // every-cycle comparison, half a cycle after the updating edge
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (tag_phase != 3'(m_phase) || slot_count != m_cnt || reply_valid != m_rv ||
          reply_is_data != m_rd || reply_word != m_rw) begin
        errors++;
        $display("FAIL %s model: got ph=%0d cnt=%h rv=%0d rd=%0d rw=%h exp ph=%0d cnt=%h rv=%0d rd=%0d rw=%h",
                 cur_req, tag_phase, slot_count, reply_valid, reply_is_data, reply_word,
                 m_phase, m_cnt, m_rv, m_rd, m_rw);
      end
    end
  end

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one command for one cycle; returns at the falling edge after it took effect
  task automatic issue(input int op, input int q, input logic [15:0] h, input string req);
    cur_req = req;
    cmd_code = 3'(op); cmd_q = 5'(q); cmd_handle = h;
    @(negedge clk);
    cmd_code = 3'd0;
  endtask

  task automatic step_until_handle(input string req);
    for (int i = 0; i < 40 && tag_phase != 3'd2; i++) issue(2, 0, 16'h0, req);
    expect_eq(req, "reached handle phase", tag_phase, 2);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R1 reset state and idle ignores
    expect_eq("R1", "phase after reset", tag_phase, 0);
    expect_eq("R1", "count after reset", slot_count, 0);
    expect_eq("R1", "no reply after reset", reply_valid, 0);
    issue(2, 0, 16'h0, "R1");
    issue(3, 0, MYH, "R1");
    issue(4, 3, 16'h0, "R10");
    expect_eq("R10", "redraw in idle ignored", tag_phase, 0);
    // R2 / R3 load with Q=3
    issue(1, 3, 16'h0, "R2");
    expect_eq("R2", "bits above Q clear", int'(slot_count & ~16'h7), 0);
    expect_eq("R3", "count equals model draw", slot_count, m_cnt);
    // R4 decrement by one
    if (tag_phase == 3'd1 && slot_count > 16'd1) begin
      c = slot_count;
      issue(2, 0, 16'h0, "R4");
      expect_eq("R4", "step lowers by one", slot_count, c - 1);
    end
    step_until_handle("R5");
    expect_eq("R5", "count zero at slot", slot_count, 0);
    issue(0, 0, 16'h0, "R12");
    expect_eq("R12", "strobe lasts one cycle", reply_valid, 0);
    issue(2, 0, 16'h0, "R8");
    expect_eq("R8", "step in handle phase ignored", slot_count, 0);
    expect_eq("R8", "phase kept", tag_phase, 2);
    // R7 mismatched ack, then saturating step
    issue(3, 0, MYH ^ 16'h0001, "R7");
    expect_eq("R7", "bad ack back to count", tag_phase, 1);
    expect_eq("R7", "bad ack keeps count", slot_count, 0);
    expect_eq("R7", "bad ack no reply", reply_valid, 0);
    issue(2, 0, 16'h0, "R4");
    expect_eq("R4", "step at zero stays zero", slot_count, 0);
    // R10 redraw keeps stored Q
    issue(4, 12, 16'h0, "R10");
    expect_eq("R10", "redraw limited by stored Q", int'(slot_count & ~16'h7), 0);
    if (tag_phase != 3'd2) step_until_handle("R10");
    issue(3, 0, MYH, "R6");
    expect_eq("R6", "data reply valid", reply_valid, 1);
    expect_eq("R6", "data flag", reply_is_data, 1);
    expect_eq("R6", "data word", reply_word, MYD);
    expect_eq("R6", "phase data", tag_phase, 3);
    issue(2, 0, 16'h0, "R8");
    expect_eq("R8", "step in data phase ignored", tag_phase, 3);
    issue(3, 0, 16'h1234, "R7");
    expect_eq("R7", "bad second ack back to count", tag_phase, 1);
    // full path to retirement
    issue(4, 0, 16'h0, "R10");
    if (tag_phase != 3'd2) step_until_handle("R9");
    issue(3, 0, MYH, "R9");
    issue(3, 0, MYH, "R9");
    expect_eq("R9", "retired", tag_phase, 4);
    expect_eq("R9", "no reply on retire", reply_valid, 0);
    issue(1, 0, 16'h0, "R9");
    expect_eq("R9", "load ignored when retired", tag_phase, 4);
    issue(4, 0, 16'h0, "R9");
    issue(2, 0, 16'h0, "R9");
    issue(3, 0, MYH, "R9");
    expect_eq("R9", "still retired, quiet", tag_phase * 2 + reply_valid, 8);
    // R11 clear
    issue(5, 0, 16'h0, "R11");
    expect_eq("R11", "clear to idle", tag_phase, 0);
    expect_eq("R11", "clear count", slot_count, 0);
    // R5 load of Q=0 replies at once
    issue(1, 0, 16'h0, "R5");
    expect_eq("R5", "Q=0 handle reply", reply_valid, 1);
    expect_eq("R5", "handle word", reply_word, MYH);
    expect_eq("R5", "handle flag", reply_is_data, 0);
    // R2 wide Q
    issue(1, 16, 16'h0, "R2");
    expect_eq("R2", "Q=16 full word", slot_count, m_cnt);
    issue(1, 20, 16'h0, "R2");
    expect_eq("R2", "Q>16 full word", slot_count, m_cnt);
    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8)       issue(1, $urandom_range(0, 4), 16'h0, "R3");
      else if (r < 55) issue(2, 0, 16'h0, "R4");
      else if (r < 75) issue(3, 0, ($urandom_range(0, 3) == 0) ? 16'hFFFF : MYH, "R6");
      else if (r < 85) issue(4, $urandom_range(0, 31), 16'h0, "R10");
      else if (r < 88) issue(5, 0, 16'h0, "R11");
      else             issue($urandom_range(6, 7), 0, 16'h0, "R12");
    end
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule